// File: doc/BRIEF.md
# Factorial-Base Sequence Counter

This block counts through every code of a mixed-radix number whose digit at position k (counted from 1 at the least significant end) has radix k+1. With n elements selected, the lowest n-1 digits take part, so one full run visits exactly n! codes. A downstream stage can turn each code into one ordering of n items. The counter advances one code per enabled clock.

The element count `n_i` may lie anywhere from 2 to 18. The block reports the end of the space in two ways. A one-cycle `done_o` strobe marks the wrap. A `valid_o` level drops at the same point and stays low until a synchronous clear re-arms it. A four-lane window output gives the four most significant active digits for the present n, so a narrow observer can follow the part of the code that changes most slowly.

Top module: `factoradic_counter`

## Requirements
- R1: After reset every digit reads 0, `valid_o` is 1 and `done_o` is 0.
- R2: An accepted increment (`inc_i`=1 while `valid_o`=1) advances digit 1 first. A digit at its maximum returns to 0 and carries into the next digit. Digit k sits in `digits_o[5k-1:5k-5]`. A full run from zero takes n! increments to reach the wrap.
- R3: Digit k never holds a value greater than k.
- R4: With `inc_i` low, no clear and `n_i` unchanged, all digits hold their values.
- R5: An accepted increment with every active digit at its maximum returns all digits to 0. `done_o` is then high in the following cycle, for that one cycle only.
- R6: `valid_o` falls together with the wrap and stays low. While it is low, increments are ignored and every digit reads 0.
- R7: `clear_i` forces all digits to 0, `valid_o` to 1 and `done_o` to 0 at the next edge.
- R8: `clear_i` takes priority over an increment in the same cycle, including an increment that would wrap. In that case no `done_o` pulse appears.
- R9: Only digits 1..n-1 are active. Every digit at position n or above reads 0 from the cycle after `n_i` is applied, whatever carries occur.
- R10: `window_o` lane j (bits [5j+4:5j], j=0..3) shows digit base+j+1. Here base is 0 when n<6 and n-5 otherwise, so lane 3 is digit n-1 once n≥6.
- R11: An `n_i` value below 2 acts as 2, and a value above 18 acts as 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear and re-arm |
| inc_i | input | 1 | Increment enable |
| n_i | input | 5 | Element count (clamped to 2..18) |
| digits_o | output | 85 | 17 digit lanes of 5 bits, digit 1 in the lowest lane |
| window_o | output | 20 | Four most significant active digits, 5 bits per lane |
| valid_o | output | 1 | High while codes remain in the current run |
| done_o | output | 1 | One-cycle strobe after the wrap |

## Verification
Clear and the wrapping increment can fall on the same edge. The bench provokes this with n=2: one increment brings the single active digit to its maximum, and then `inc_i` and `clear_i` are driven together. The expected result is zero digits, `valid_o` still high and no `done_o` pulse. A second collision occurs when `n_i` shrinks while digits above the new length hold nonzero values. The bench then expects those digits at zero on the next edge, with the lower digits left intact. Both cases are judged against a behavioural model that is compared with every output on every clock.

// File: rtl/factoradic_pkg.sv
package factoradic_pkg;
  localparam int DEF_MAX_ELEMS = 18;
  localparam int DEF_WIN_LANES = 4;

  function automatic int lane_width(input int max_elems);
    return $clog2(max_elems);
  endfunction
endpackage

// File: rtl/fd_len_decode.sv
module fd_len_decode #(
  parameter int MAX_ELEMS = 18,
  parameter int WIN       = 4,
  parameter int NW        = 5,
  localparam int ND       = MAX_ELEMS - 1
) (
  input  logic [NW-1:0] n_i,
  output logic [ND-1:0] active_o,
  output logic [NW-1:0] base_o
);
  logic [NW-1:0] n_eff;
  logic [NW-1:0] n_act;

  always_comb begin
    if (n_i < NW'(2))              n_eff = NW'(2);
    else if (n_i > NW'(MAX_ELEMS)) n_eff = NW'(MAX_ELEMS);
    else                           n_eff = n_i;
  end

  assign n_act  = n_eff - NW'(1);
  assign base_o = (n_act > NW'(WIN)) ? n_act - NW'(WIN) : '0;

  for (genvar i = 0; i < ND; i++) begin : g_act
    assign active_o[i] = NW'(i + 1) < n_eff;
  end
endmodule

// File: rtl/fd_digit_cell.sv
module fd_digit_cell #(
  parameter int MAXV = 1,
  parameter int LW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          active_i,
  input  logic          carry_i,
  output logic          at_max_o,
  output logic [LW-1:0] digit_o
);
  localparam int W = $clog2(MAXV + 1);
  logic [W-1:0] q;

  assign at_max_o = (q == W'(MAXV));
  assign digit_o  = LW'(q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q <= '0;
    else if (clear_i || !active_i) q <= '0;
    else if (carry_i)             q <= at_max_o ? '0 : q + W'(1);
  end
endmodule

// File: rtl/fd_window_mux.sv
module fd_window_mux #(
  parameter int ND  = 17,
  parameter int LW  = 5,
  parameter int NW  = 5,
  parameter int WIN = 4
) (
  input  logic [ND*LW-1:0]  digits_i,
  input  logic [NW-1:0]     base_i,
  output logic [WIN*LW-1:0] window_o
);
  for (genvar j = 0; j < WIN; j++) begin : g_lane
    logic [LW-1:0] sel;
    always_comb begin
      sel = '0;
      for (int k = 0; k < ND; k++) begin
        if (base_i + NW'(j) == NW'(k)) sel = digits_i[k*LW +: LW];
      end
    end
    assign window_o[j*LW +: LW] = sel;
  end
endmodule

// File: rtl/factoradic_counter.sv
module factoradic_counter
  import factoradic_pkg::*;
#(
  parameter int MAX_ELEMS = DEF_MAX_ELEMS,
  parameter int WIN       = DEF_WIN_LANES,
  localparam int ND       = MAX_ELEMS - 1,
  localparam int LW       = lane_width(MAX_ELEMS),
  localparam int NW       = $clog2(MAX_ELEMS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic [NW-1:0]     n_i,
  output logic [ND*LW-1:0]  digits_o,
  output logic [WIN*LW-1:0] window_o,
  output logic              valid_o,
  output logic              done_o
);
  logic [ND-1:0] active;
  logic [ND-1:0] at_max;
  logic [ND-1:0] chain;
  logic [NW-1:0] base;
  logic          step;
  logic          wrap;
  logic          valid_q;
  logic          done_q;

  fd_len_decode #(.MAX_ELEMS(MAX_ELEMS), .WIN(WIN), .NW(NW)) u_len (
    .n_i      (n_i),
    .active_o (active),
    .base_o   (base)
  );

  assign step     = inc_i && valid_q && !clear_i;
  assign chain[0] = step;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    if (i > 0) begin : g_chain
      assign chain[i] = chain[i-1] && at_max[i-1];
    end
    fd_digit_cell #(.MAXV(i + 1), .LW(LW)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clear_i),
      .active_i (active[i]),
      .carry_i  (chain[i]),
      .at_max_o (at_max[i]),
      .digit_o  (digits_o[i*LW +: LW])
    );
  end

  // wrap: every active digit saturated
  assign wrap = step && (&(at_max | ~active));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (clear_i) begin
      valid_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= wrap;
      if (wrap) valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;

  fd_window_mux #(.ND(ND), .LW(LW), .NW(NW), .WIN(WIN)) u_win (
    .digits_i (digits_o),
    .base_i   (base),
    .window_o (window_o)
  );
endmodule

// File: rtl/factoradic_counter_chk.sv
module factoradic_counter_chk #(
  parameter int ND = 17,
  parameter int LW = 5,
  parameter int NW = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             inc_i,
  input logic [NW-1:0]    n_i,
  input logic [ND*LW-1:0] digits_o,
  input logic             valid_o,
  input logic             done_o
);
  for (genvar i = 0; i < ND; i++) begin : g_rng
    assert_digit_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digits_o[i*LW +: LW] <= LW'(i + 1));
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clear_i && $stable(n_i)) |=> $stable(digits_o));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (digits_o == '0));

  assert_done_drops_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (digits_o == '0));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (digits_o == '0 && valid_o && !done_o));
endmodule

bind factoradic_counter factoradic_counter_chk #(.ND(ND), .LW(LW), .NW(NW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .inc_i    (inc_i),
  .n_i      (n_i),
  .digits_o (digits_o),
  .valid_o  (valid_o),
  .done_o   (done_o)
);

// File: tb/factoradic_counter_test.sv
module factoradic_counter_test;
  localparam int ND = 17;
  localparam int LW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clear_i = 1'b0;
  logic          inc_i = 1'b0;
  logic [4:0]    n_i = 5'd2;
  logic [84:0]   digits_o;
  logic [19:0]   window_o;
  logic          valid_o;
  logic          done_o;

  int   md [ND];
  int   mv = 1;
  int   mdn = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  string cur_tag = "R1";

  factoradic_counter uut (
    .clk_i, .rst_ni, .clear_i, .inc_i, .n_i,
    .digits_o, .window_o, .valid_o, .done_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampn(input int n);
    if (n < 2) return 2;
    if (n > 18) return 18;
    return n;
  endfunction

  function automatic int fact(input int n);
    int f = 1;
    for (int i = 2; i <= n; i++) f *= i;
    return f;
  endfunction

  task automatic model_step();
    int na = clampn(int'(n_i)) - 1;
    if (clear_i) begin
      for (int i = 0; i < ND; i++) md[i] = 0;
      mv = 1; mdn = 0;
    end else begin
      mdn = 0;
      if (inc_i && mv == 1) begin
        bit allmax = 1'b1;
        for (int i = 0; i < na; i++) if (md[i] != i + 1) allmax = 1'b0;
        if (allmax) begin
          for (int i = 0; i < ND; i++) md[i] = 0;
          mdn = 1; mv = 0;
        end else begin
          bit go = 1'b1;
          for (int i = 0; i < na; i++) begin
            if (go) begin
              if (md[i] == i + 1) md[i] = 0;
              else begin md[i] = md[i] + 1; go = 1'b0; end
            end
          end
        end
      end
    end
    for (int i = na; i < ND; i++) md[i] = 0;
  endtask

  task automatic compare();
    int na = clampn(int'(n_i)) - 1;
    int base = (na > 4) ? na - 4 : 0;
    for (int i = 0; i < ND; i++)
      chk(cur_tag, $sformatf("digit%0d", i + 1), int'(digits_o[i*LW +: LW]), md[i]);
    chk(cur_tag, "valid", int'(valid_o), mv);
    chk(cur_tag, "done", int'(done_o), mdn);
    // R10 window lanes
    for (int j = 0; j < 4; j++)
      chk("R10", $sformatf("win%0d", j), int'(window_o[j*LW +: LW]), md[base + j]);
  endtask

  task automatic cycle(input bit inc, input bit clr, input int n);
    inc_i = inc; clear_i = clr; n_i = 5'(n);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic run_full(input int n, input string tag);
    int cnt = 0;
    do begin
      cycle(1'b1, 1'b0, n);
      cnt++;
    end while (!done_o && cnt < 10000);
    chk(tag, "steps_to_wrap", cnt, fact(clampn(n)));
  endtask

  initial begin
    for (int i = 0; i < ND; i++) md[i] = 0;
    repeat (3) @(negedge clk_i);
    cur_tag = "R1";
    compare();
    rst_ni = 1'b1;
    cycle(1'b0, 1'b0, 4);

    cur_tag = "R4";
    repeat (3) cycle(1'b0, 1'b0, 4);
    repeat (5) cycle(1'b1, 1'b0, 4);
    repeat (3) cycle(1'b0, 1'b0, 4);
    cycle(1'b0, 1'b1, 4);

    cur_tag = "R2";
    run_full(4, "R2");
    cur_tag = "R5";
    chk("R5", "done_at_wrap", int'(done_o), 1);
    cycle(1'b0, 1'b0, 4);
    chk("R5", "done_one_cycle", int'(done_o), 0);
    cur_tag = "R6";
    repeat (4) cycle(1'b1, 1'b0, 4);
    chk("R6", "valid_stays_low", int'(valid_o), 0);
    chk("R6", "digits_stay_zero", int'(digits_o != '0), 0);

    cur_tag = "R7";
    cycle(1'b0, 1'b1, 4);
    repeat (10) cycle(1'b1, 1'b0, 4);
    cycle(1'b1, 1'b1, 4);
    chk("R7", "valid_rearmed", int'(valid_o), 1);

    cur_tag = "R8";
    cycle(1'b0, 1'b1, 2);
    cycle(1'b1, 1'b0, 2);
    chk("R8", "digit1_at_max", int'(digits_o[4:0]), 1);
    cycle(1'b1, 1'b1, 2);
    chk("R8", "no_done_on_clear", int'(done_o), 0);
    chk("R8", "valid_kept", int'(valid_o), 1);
    chk("R8", "digit1_cleared", int'(digits_o[4:0]), 0);

    cur_tag = "R9";
    cycle(1'b0, 1'b1, 6);
    repeat (100) cycle(1'b1, 1'b0, 6);
    cycle(1'b0, 1'b0, 3);
    chk("R9", "upper_zero", int'(digits_o[84:10] != '0), 0);
    repeat (3) cycle(1'b1, 1'b0, 3);
    cycle(1'b0, 1'b0, 6);
    repeat (20) cycle(1'b1, 1'b0, 6);

    cur_tag = "R11";
    cycle(1'b0, 1'b1, 0);
    run_full(0, "R11");
    cycle(1'b0, 1'b1, 31);
    repeat (60) cycle(1'b1, 1'b0, 31);

    cur_tag = "R3";
    cycle(1'b0, 1'b1, 7);
    run_full(7, "R3");

    cur_tag = "R10";
    cycle(1'b0, 1'b1, 18);
    repeat (3000) cycle(1'b1, 1'b0, 18);
    cycle(1'b0, 1'b1, 5);
    run_full(5, "R10");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule